// File: doc/BRIEF.md
# Asynchronous receive FIFO controller

This block is the receive half of an asynchronous serial channel. A deserializer front end hands it one character per valid pulse, with parity-error, framing-error and break marks attached. Characters go into a 32-entry store. They reach the host only in blocks: either a full block, when the store fills, or a partial block that the host asks for with a forced-read command after the line has gone quiet. The host reads a block through a window of registers addressed relative to the block start. It then hands the space back with a release command.

Conditions are reported in two 8-bit sticky status banks, each with its own mask, and one registered interrupt line. Commands take a fixed number of cycles. While one is in progress, a busy flag is visible and further command writes are dropped.

Top module: `rx_fifo_ctrl`

## Requirements
- R1: After reset, the state register (address 5) and both status banks (addresses 0 and 1) read zero, and `irq` is low.
- R2: Stored characters keep their arrival order. A read of window address 32+k returns the k-th character of the current block, counted from the first character not yet released.
- R3: When the store holds 32 characters and no block is held, a 32-character block is declared and status bank 0 bit 0 (block full) is set.
- R4: A character that arrives while the store holds 32 characters, after any release taking effect on that edge, is dropped and sets status bank 0 bit 3 (overflow). A character arriving on the release edge itself is stored.
- R5: When characters are stored, no block is held, and no character has arrived for IDLE_LIM cycles, status bank 0 bit 2 (idle timeout) is set. It is set once per quiet period.
- R6: A forced-read command (bit 1 of the command byte) with no block held declares a block of all stored characters and sets status bank 0 bit 1 (block done). The count register (address 4) returns the block length in its low 5 bits, so a full block reads 0.
- R7: A release command (bit 0) with a block held frees that block's space. The next block starts at the first character after it.
- R8: A command byte written to address 6 while busy is ignored. An accepted command sets the state register bit 0 (busy) for CMD_LAT cycles and takes effect on the last of them. State register bit 1 shows a held block.
- R9: A receiver reset command (bit 2, which outranks bit 1, which outranks bit 0) empties the store and drops any held block.
- R10: A stored character with a parity mark sets bank 0 bit 4, with a framing mark sets bank 0 bit 5, and with a break mark sets bank 1 bit 0.
- R11: Reading a status bank returns its bits and clears them. An event on the same edge as the read stays set.
- R12: Mask registers (address 2 for bank 0, 3 for bank 1) are read/write, and a set bit hides that status bit from `irq` without stopping it from latching. `irq` is high one cycle after any unmasked status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One character offered this cycle |
| rx_data | input | 8 | Character value |
| rx_perr | input | 1 | Parity error mark for the character |
| rx_ferr | input | 1 | Framing error mark for the character |
| rx_brk | input | 1 | Break mark for the character |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 6 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Registered interrupt request |

## Verification
Two collisions matter here, and the bench forces each one by driving stimulus on the exact edge it wants. In the first, a release takes effect on the same edge that a character arrives into a full store. The command is timed so its last busy cycle meets the character. The character must be stored and appear at window offset 0 of the next forced block, while an earlier overflowing character must be gone. In the second, a status read shares an edge with a parity-marked character. The read must return the old bits, and the parity bit must still be there on the following read. A behavioural model in the bench predicts every read and the interrupt line each cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned ST0_FULL = 0;
  localparam int unsigned ST0_DONE = 1;
  localparam int unsigned ST0_IDLE = 2;
  localparam int unsigned ST0_OVF  = 3;
  localparam int unsigned ST0_PAR  = 4;
  localparam int unsigned ST0_FRM  = 5;
  localparam int unsigned ST1_BRK  = 0;

  typedef enum logic [2:0] {
    RA_STAT0 = 3'd0,
    RA_STAT1 = 3'd1,
    RA_MASK0 = 3'd2,
    RA_MASK1 = 3'd3,
    RA_COUNT = 3'd4,
    RA_STATE = 3'd5,
    RA_CMD   = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic rx_reset;
    logic force_rd;
    logic release_blk;
  } rx_cmd_t;
endpackage

// File: rtl/rxf_mem.sv
module rxf_mem #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/rxf_cmd.sv
module rxf_cmd
  import rxf_pkg::*;
#(
  parameter int unsigned CMD_LAT = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    cmd_wr,
  input  rx_cmd_t cmd_in,
  output logic    busy,
  output logic    do_rst,
  output logic    do_frc,
  output logic    do_rel
);
  localparam int unsigned BW = $clog2(CMD_LAT + 1);

  logic [BW-1:0] busy_cnt;
  rx_cmd_t       cmd_q;
  logic          exec;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      cmd_q    <= '0;
    end else if (cmd_wr && busy_cnt == '0) begin
      busy_cnt <= BW'(CMD_LAT);
      cmd_q    <= cmd_in;
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - BW'(1);
    end
  end

  assign busy   = (busy_cnt != '0);
  assign exec   = (busy_cnt == BW'(1));
  assign do_rst = exec && cmd_q.rx_reset;
  assign do_frc = exec && !cmd_q.rx_reset && cmd_q.force_rd;
  assign do_rel = exec && !cmd_q.rx_reset && !cmd_q.force_rd && cmd_q.release_blk;

  // R8: a write while busy leaves the held command untouched
  a_r8_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    busy && cmd_wr |=> $stable(cmd_q));
  // R8: at most one command action per cycle
  a_r8_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({do_rst, do_frc, do_rel}));
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned IDLE_LIM = 16,
  localparam int unsigned PW      = $clog2(DEPTH),
  localparam int unsigned CW      = PW + 1,
  localparam int unsigned IW      = $clog2(IDLE_LIM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          rx_brk,
  input  logic          do_rst,
  input  logic          do_frc,
  input  logic          do_rel,
  output logic          wr_en,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] head,
  output logic          pending,
  output logic [CW-1:0] blen,
  output logic          ev_full,
  output logic          ev_done,
  output logic          ev_idle,
  output logic          ev_ovf,
  output logic          ev_par,
  output logic          ev_frm,
  output logic          ev_brk
);
  logic [CW-1:0] count;
  logic [CW-1:0] rel_amt;
  logic [CW-1:0] used;
  logic [IW-1:0] idle_cnt;
  logic          fired;
  logic          idle_run;

  assign rel_amt = (do_rel && pending) ? blen : '0;
  assign used    = count - rel_amt;
  assign wr_en   = rx_valid && !do_rst && (used != CW'(DEPTH));
  assign ev_ovf  = rx_valid && !do_rst && (used == CW'(DEPTH));
  assign ev_par  = wr_en && rx_perr;
  assign ev_frm  = wr_en && rx_ferr;
  assign ev_brk  = wr_en && rx_brk;
  assign ev_full = !pending && (count == CW'(DEPTH)) && !do_rst;
  assign ev_done = !pending && (count != CW'(DEPTH)) && do_frc;

  // storage pointers
  always_ff @(posedge clk) begin
    if (rst || do_rst) begin
      count <= '0;
      head  <= '0;
      wptr  <= '0;
    end else begin
      count <= used + CW'(wr_en);
      head  <= head + rel_amt[PW-1:0];
      wptr  <= wptr + PW'(wr_en);
    end
  end

  // block held for the host
  always_ff @(posedge clk) begin
    if (rst || do_rst) begin
      pending <= 1'b0;
      blen    <= '0;
    end else if (do_rel && pending) begin
      pending <= 1'b0;
      blen    <= '0;
    end else if (ev_full) begin
      pending <= 1'b1;
      blen    <= CW'(DEPTH);
    end else if (ev_done) begin
      pending <= 1'b1;
      blen    <= count;
    end
  end

  // idle timeout
  assign idle_run = (count != '0) && !pending && !fired;
  assign ev_idle  = !do_rst && !rx_valid && idle_run && (idle_cnt == IW'(IDLE_LIM - 1));

  always_ff @(posedge clk) begin
    if (rst || do_rst || rx_valid) begin
      idle_cnt <= '0;
      fired    <= 1'b0;
    end else if (ev_idle) begin
      idle_cnt <= '0;
      fired    <= 1'b1;
    end else if (idle_run) begin
      idle_cnt <= idle_cnt + IW'(1);
    end else begin
      idle_cnt <= '0;
    end
  end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  a_r4_drop_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !wr_en && !do_rst |=> wptr == $past(wptr));
  a_r3_full_block: assert property (@(posedge clk) disable iff (rst)
    !pending && count == CW'(DEPTH) && !do_rst |=> pending && blen == CW'(DEPTH));
  a_r9_reset_empties: assert property (@(posedge clk) disable iff (rst)
    do_rst |=> count == '0 && !pending);
  a_r5_single_idle: assert property (@(posedge clk) disable iff (rst)
    ev_idle |=> !ev_idle);
endmodule

// File: rtl/rxf_stat.sv
module rxf_stat #(
  parameter int unsigned RW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0][RW-1:0] ev,
  input  logic [1:0]         clr,
  input  logic [1:0]         mwr,
  input  logic [RW-1:0]      wdata,
  output logic [1:0][RW-1:0] stat,
  output logic [1:0][RW-1:0] mask,
  output logic               irq
);
  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        stat[b] <= '0;
        mask[b] <= '0;
      end else begin
        stat[b] <= (clr[b] ? '0 : stat[b]) | ev[b];
        if (mwr[b]) mask[b] <= wdata;
      end
    end

    // R11: an event is never lost to a read on the same edge
    a_r11_event_kept: assert property (@(posedge clk) disable iff (rst)
      ev[b] != '0 |=> (stat[b] & $past(ev[b])) == $past(ev[b]));
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (|(stat[0] & ~mask[0])) || (|(stat[1] & ~mask[1]));
  end

  a_r12_quiet_when_masked: assert property (@(posedge clk) disable iff (rst)
    ((stat[0] & ~mask[0]) == '0) && ((stat[1] & ~mask[1]) == '0) |=> !irq);
endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 6,
  parameter int unsigned IDLE_LIM = 16,
  parameter int unsigned CMD_LAT  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          rx_brk,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;
  localparam int unsigned RW = 8;

  logic          busy, do_rst, do_frc, do_rel, cmd_wr;
  logic          wr_en, pending, is_win;
  logic [PW-1:0] wptr, head, raddr;
  logic [CW-1:0] blen;
  logic          ev_full, ev_done, ev_idle, ev_ovf, ev_par, ev_frm, ev_brk;
  logic [1:0][RW-1:0] ev, stat, mask;
  logic [1:0]    clr, mwr;
  logic [DW-1:0] mem_rd;
  logic [RW-1:0] reg_val, rd_q;
  logic          win_q;

  assign is_win = reg_addr[AW-1];
  assign cmd_wr = reg_wr && (reg_addr == AW'(RA_CMD));
  assign clr    = {reg_rd && (reg_addr == AW'(RA_STAT1)), reg_rd && (reg_addr == AW'(RA_STAT0))};
  assign mwr    = {reg_wr && (reg_addr == AW'(RA_MASK1)), reg_wr && (reg_addr == AW'(RA_MASK0))};
  assign raddr  = head + reg_addr[PW-1:0];

  rxf_cmd #(.CMD_LAT(CMD_LAT)) u_cmd (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_in(rx_cmd_t'(reg_wdata[2:0])),
    .busy(busy), .do_rst(do_rst), .do_frc(do_frc), .do_rel(do_rel)
  );

  rxf_ctrl #(.DEPTH(DEPTH), .IDLE_LIM(IDLE_LIM)) u_ctrl (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .rx_brk(rx_brk), .do_rst(do_rst), .do_frc(do_frc), .do_rel(do_rel),
    .wr_en(wr_en), .wptr(wptr), .head(head), .pending(pending), .blen(blen),
    .ev_full(ev_full), .ev_done(ev_done), .ev_idle(ev_idle), .ev_ovf(ev_ovf),
    .ev_par(ev_par), .ev_frm(ev_frm), .ev_brk(ev_brk)
  );

  rxf_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wptr), .wdata(rx_data), .raddr(raddr), .rdata(mem_rd)
  );

  always_comb begin
    ev = '0;
    ev[0][ST0_FULL] = ev_full;
    ev[0][ST0_DONE] = ev_done;
    ev[0][ST0_IDLE] = ev_idle;
    ev[0][ST0_OVF]  = ev_ovf;
    ev[0][ST0_PAR]  = ev_par;
    ev[0][ST0_FRM]  = ev_frm;
    ev[1][ST1_BRK]  = ev_brk;
  end

  rxf_stat #(.RW(RW)) u_stat (
    .clk(clk), .rst(rst), .ev(ev), .clr(clr), .mwr(mwr), .wdata(reg_wdata),
    .stat(stat), .mask(mask), .irq(irq)
  );

  always_comb begin
    reg_val = '0;
    if      (reg_addr == AW'(RA_STAT0)) reg_val = stat[0];
    else if (reg_addr == AW'(RA_STAT1)) reg_val = stat[1];
    else if (reg_addr == AW'(RA_MASK0)) reg_val = mask[0];
    else if (reg_addr == AW'(RA_MASK1)) reg_val = mask[1];
    else if (reg_addr == AW'(RA_COUNT)) reg_val = RW'(blen[PW-1:0]);
    else if (reg_addr == AW'(RA_STATE)) reg_val = RW'({pending, busy});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      win_q <= 1'b0;
    end else begin
      win_q <= reg_rd && is_win;
      if (reg_rd) rd_q <= reg_val;
    end
  end

  assign reg_rdata = win_q ? RW'(mem_rd) : rd_q;

  // R7: a release with a held block always clears the held state
  a_r7_release_frees: assert property (@(posedge clk) disable iff (rst)
    do_rel && pending |=> !pending);
endmodule

// File: tb/test_rx_fifo_ctrl.sv
`timescale 1ns/1ps
module test_rx_fifo_ctrl;
  localparam int DEPTH = 32;
  localparam int IDLE  = 16;
  localparam int LAT   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic [7:0] rx_data = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq;

  always #4 clk = ~clk;

  rx_fifo_ctrl #(.DEPTH(DEPTH), .DW(8), .AW(6), .IDLE_LIM(IDLE), .CMD_LAT(LAT)) i_rx_fifo_ctrl (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_brk(rx_brk), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  string cur_tag = "R2";

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mm[DEPTH];
  int m_head, m_wp, m_cnt, m_pend, m_blen, m_busy, m_cmd, m_idle, m_fired;
  int m_s0, m_s1, m_k0, m_k1, m_irq, m_rd, m_rdv;
  string m_tag;

  always @(posedge clk) begin
    if (rst) begin
      foreach (mm[i]) mm[i] = 0;
      m_head = 0; m_wp = 0; m_cnt = 0; m_pend = 0; m_blen = 0; m_busy = 0; m_cmd = 0;
      m_idle = 0; m_fired = 0; m_s0 = 0; m_s1 = 0; m_k0 = 0; m_k1 = 0; m_irq = 0; m_rdv = 0;
    end else begin
      int exec, drst, dfrc, drel, rel_amt, used, wr, ovf, full_ev, done_ev, run, idle_ev;
      int ev0, ev1, old_cnt, a, nirq;
      exec = (m_busy == 1);
      drst = exec && ((m_cmd >> 2) & 1);
      dfrc = exec && !drst && ((m_cmd >> 1) & 1);
      drel = exec && !drst && !dfrc && (m_cmd & 1);
      rel_amt = (drel && m_pend) ? m_blen : 0;
      used = m_cnt - rel_amt;
      wr  = rx_valid && !drst && (used != DEPTH);
      ovf = rx_valid && !drst && (used == DEPTH);
      a = int'(reg_addr);
      m_rdv = reg_rd;
      m_tag = cur_tag;
      if (reg_rd) begin
        case (a)
          0: m_rd = m_s0;
          1: m_rd = m_s1;
          2: m_rd = m_k0;
          3: m_rd = m_k1;
          4: m_rd = m_blen % 32;
          5: m_rd = (m_pend << 1) | (m_busy != 0);
          default: m_rd = (a >= 32) ? mm[(m_head + a - 32) % DEPTH] : 0;
        endcase
      end
      full_ev = !m_pend && m_cnt == DEPTH && !drst;
      done_ev = !m_pend && m_cnt != DEPTH && dfrc;
      run = (m_cnt != 0) && !m_pend && !m_fired;
      idle_ev = !drst && !rx_valid && run && (m_idle == IDLE - 1);
      ev0 = full_ev | (done_ev << 1) | (idle_ev << 2) | (ovf << 3)
          | ((wr && rx_perr) << 4) | ((wr && rx_ferr) << 5);
      ev1 = wr && rx_brk;
      nirq = ((m_s0 & ~m_k0 & 255) != 0) || ((m_s1 & ~m_k1 & 255) != 0);
      m_irq = nirq;
      if (drst || rx_valid) begin m_idle = 0; m_fired = 0; end
      else if (idle_ev) begin m_idle = 0; m_fired = 1; end
      else if (run) m_idle++;
      else m_idle = 0;
      old_cnt = m_cnt;
      if (drst) begin m_pend = 0; m_blen = 0; end
      else if (drel && m_pend) begin m_pend = 0; m_blen = 0; end
      else if (full_ev) begin m_pend = 1; m_blen = DEPTH; end
      else if (done_ev) begin m_pend = 1; m_blen = old_cnt; end
      if (wr) mm[m_wp] = int'(rx_data);
      if (drst) begin m_cnt = 0; m_head = 0; m_wp = 0; end
      else begin
        m_cnt  = used + wr;
        m_head = (m_head + rel_amt) % DEPTH;
        m_wp   = (m_wp + wr) % DEPTH;
      end
      if (reg_wr && a == 6 && m_busy == 0) begin m_busy = LAT; m_cmd = reg_wdata & 7; end
      else if (m_busy != 0) m_busy--;
      m_s0 = ((reg_rd && a == 0) ? 0 : m_s0) | ev0;
      m_s1 = ((reg_rd && a == 1) ? 0 : m_s1) | ev1;
      if (reg_wr && a == 2) m_k0 = reg_wdata;
      if (reg_wr && a == 3) m_k1 = reg_wdata;
    end
  end

  // compare away from the active edge, every cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R12 irq", int'(irq), m_irq);
      if (m_rdv) chk(m_tag, int'(reg_rdata), m_rd);
    end
  end

  // ---------------- stimulus tasks (entered at a falling edge) ----------------
  task automatic idle_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int d, bit p = 0, bit f = 0, bit b = 0);
    rx_valid = 1; rx_data = 8'(d); rx_perr = p; rx_ferr = f; rx_brk = b;
    @(negedge clk);
    rx_valid = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
  endtask

  task automatic wr(int a, int d);
    reg_wr = 1; reg_addr = 6'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(int a, string tag, output int v);
    reg_rd = 1; reg_addr = 6'(a); cur_tag = tag;
    @(negedge clk);
    reg_rd = 0;
    v = int'(reg_rdata);
  endtask

  task automatic cmd(int c);
    wr(6, c);
    idle_cyc(LAT);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq", int'(irq), 0);
    rd(5, "R1 state", v);  chk("R1 state", v, 0);
    rd(0, "R1 stat0", v);  chk("R1 stat0", v, 0);
    rd(1, "R1 stat1", v);  chk("R1 stat1", v, 0);

    // R5: partial data then quiet line
    for (int i = 0; i < 5; i++) send(8'h11 + i);
    idle_cyc(IDLE + 4);
    chk("R12 irq raised", int'(irq), 1);
    rd(0, "R5 stat0", v);  chk("R5 idle bit", v, 4);

    // R8: force read, then a release written while busy is ignored
    wr(6, 2);
    wr(6, 1);
    rd(5, "R8 busy", v);   chk("R8 busy", v, 1);
    idle_cyc(2);
    rd(5, "R8 state", v);  chk("R8 held, release ignored", v, 2);
    rd(0, "R6 stat0", v);  chk("R6 done bit", v, 2);
    rd(4, "R6 count", v);  chk("R6 count", v, 5);
    for (int k = 0; k < 5; k++) begin
      rd(32 + k, "R2 window", v); chk("R2 order", v, 8'h11 + k);
    end
    cmd(1);
    rd(5, "R7 state", v);  chk("R7 released", v, 0);

    // R3: fill the store
    for (int i = 0; i < DEPTH; i++) send(8'h40 + i);
    idle_cyc(2);
    rd(0, "R3 stat0", v);  chk("R3 full bit", v, 1);
    rd(4, "R6 count32", v); chk("R6 masked count", v, 0);
    rd(32, "R2 first", v); chk("R2 first", v, 8'h40);
    rd(63, "R2 last", v);  chk("R2 last", v, 8'h40 + DEPTH - 1);

    // R4: overflow, then a character on the release edge
    send(8'h99);
    rd(0, "R4 stat0", v);  chk("R4 overflow bit", v, 8);
    wr(6, 1);
    @(negedge clk);
    send(8'h77);
    idle_cyc(2);
    rd(5, "R7 state", v);  chk("R7 released", v, 0);
    cmd(2);
    rd(4, "R4 count", v);  chk("R4 kept on release edge", v, 1);
    rd(32, "R7 next block", v); chk("R7 next block start", v, 8'h77);
    cmd(1);

    // R10 / R12: marks with everything masked
    rd(0, "R11 clear0", v);
    rd(1, "R11 clear1", v);
    wr(2, 8'hFF);
    wr(3, 8'hFF);
    send(8'h01, 1, 0, 0);
    send(8'h02, 0, 1, 0);
    send(8'h00, 0, 0, 1);
    idle_cyc(2);
    chk("R12 masked irq", int'(irq), 0);
    rd(2, "R12 mask0", v); chk("R12 mask0", v, 8'hFF);
    rd(0, "R10 stat0", v); chk("R10 parity+framing", v, 8'h30);
    rd(1, "R10 stat1", v); chk("R10 break", v, 1);
    wr(2, 0);
    idle_cyc(IDLE + 4);
    chk("R12 unmasked irq", int'(irq), 1);

    // R11: read and parity event on the same edge
    reg_rd = 1; reg_addr = 6'd0; cur_tag = "R11 collide";
    rx_valid = 1; rx_data = 8'h05; rx_perr = 1;
    @(negedge clk);
    reg_rd = 0; rx_valid = 0; rx_perr = 0;
    v = int'(reg_rdata); chk("R11 old bits", v, 4);
    rd(0, "R11 kept", v);  chk("R11 event kept", v, 8'h10);

    // R9: receiver reset
    cmd(4);
    rd(5, "R9 state", v);  chk("R9 empty", v, 0);
    cmd(2);
    rd(4, "R9 count", v);  chk("R9 zero block", v, 0);
    rd(0, "R9 stat0", v);  chk("R9 done on empty", v, 2);
    cmd(1);
    idle_cyc(4);
    finish_run();
  end
endmodule